// File: doc/BRIEF.md
# Sequenced Shift-and-Add Multiplier

This block multiplies two unsigned operands held in its own word-addressed data memory and writes the full-width product back into that memory. A small datapath does the work: an eight-entry register file, an ALU with add, subtract, AND and single-bit shifts, and the memory. A hardwired state machine drives that datapath. In each state the machine emits one control word. The word names a destination register and two source registers. It chooses between register B and a small immediate for the second ALU input, and chooses the ALU function. It also chooses between the ALU result and memory data for writeback, and it carries the register-write and memory-write enables. The ALU result is always the memory address, and register B is always the memory write data.

Before a run, the surrounding logic places the multiplicand at word 0 and the multiplier at word 1 through a host port. It then pulses `start`. The machine clears a base register and loads both operands relative to it. It clears the accumulator and then loops. Each pass samples the multiplier's low bit and shifts the multiplier right. It adds the multiplicand into the accumulator only when the sampled bit was set, and then shifts the multiplicand left. The loop ends as soon as the multiplier reaches zero. The accumulator is then stored to word 2 and `done` pulses for one cycle.

Top module: `seqmul_core`

## Requirements
- R1: After reset, `busy` and `done` are 0.
- R2: While idle with `start` at 0, the block stays idle (`busy` stays 0) and no memory word changes.
- R3: A cycle in which `start` is 1 while idle makes `busy` 1 from the next clock edge on.
- R4: After a run, word 2 holds the 2*OP_W-bit unsigned product of word 0 and word 1, including operands of 0 and 2^OP_W-1.
- R5: During a run, the block writes no memory word other than word 2, so words 0 and 1 are unchanged afterwards.
- R6: `done` is high for exactly one cycle per run, and `busy` is 0 on the cycle after it.
- R7: The loop runs one pass per multiplier bit up to its highest set bit, or exactly one pass when the multiplier is 0. A pass takes 4 cycles when its sampled bit is 1 and 3 cycles when it is 0. Counting the start edge as cycle 1, `done` is first seen in cycle 6 plus the total pass cycles.
- R8: Memory is word-addressed: host address k selects the same word that the datapath reaches when its ALU output is k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| host_we | input | 1 | Host memory write enable, honoured only when idle |
| host_addr | input | AW | Host word address for write and read |
| host_wdata | input | 2*OP_W | Host write data |
| host_rdata | output | 2*OP_W | Memory word at host_addr (combinational) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the product is stored |

## Verification
The bench builds the block with OP_W = 8 and an eight-word memory, the default values. At that width the largest operand, 255, and the zero operand are both cheap to reach. A full 16-bit product such as 255*255 = 65025 fills the product word. The eight-bit multiplier lets the early-exit loop length vary from one pass to eight, so the exact done latency of R7 can be checked against multipliers with different highest set bits and bit patterns.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

    typedef enum logic [2:0] {
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_SRL,
        FN_SLL
    } alu_fn_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR_BASE,
        ST_LD_MCAND,
        ST_LD_MPLIER,
        ST_CLR_ACC,
        ST_TAKE_BIT,
        ST_SHIFT_MPLIER,
        ST_ACCUM,
        ST_SHIFT_MCAND,
        ST_STORE,
        ST_FINISH
    } step_e;

    localparam int RIDX_W = 3;
    localparam int IMM_W  = 3;

    // register roles
    localparam logic [RIDX_W-1:0] REG_BASE   = 3'd0;
    localparam logic [RIDX_W-1:0] REG_MCAND  = 3'd1;
    localparam logic [RIDX_W-1:0] REG_MPLIER = 3'd2;
    localparam logic [RIDX_W-1:0] REG_ACC    = 3'd3;
    localparam logic [RIDX_W-1:0] REG_BIT    = 3'd4;

    // memory word offsets from the base register
    localparam logic [IMM_W-1:0] OFS_MCAND  = 3'd0;
    localparam logic [IMM_W-1:0] OFS_MPLIER = 3'd1;
    localparam logic [IMM_W-1:0] OFS_PROD   = 3'd2;

    typedef struct packed {
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] src_b;
        logic              use_imm;
        alu_fn_e           fn;
        logic              wb_mem;
        logic              reg_we;
        logic              mem_we;
        logic [IMM_W-1:0]  imm;
    } cword_t;

endpackage

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
    import seqmul_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   bit_set,
    input  logic   mplier_nz,
    output cword_t cw,
    output logic   busy,
    output logic   done
);

    typedef struct packed {
        step_e step;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.step)
            ST_IDLE:         if (start) st_d.step = ST_CLR_BASE;
            ST_CLR_BASE:     st_d.step = ST_LD_MCAND;
            ST_LD_MCAND:     st_d.step = ST_LD_MPLIER;
            ST_LD_MPLIER:    st_d.step = ST_CLR_ACC;
            ST_CLR_ACC:      st_d.step = ST_TAKE_BIT;
            ST_TAKE_BIT:     st_d.step = ST_SHIFT_MPLIER;
            ST_SHIFT_MPLIER: st_d.step = bit_set ? ST_ACCUM : ST_SHIFT_MCAND;
            ST_ACCUM:        st_d.step = ST_SHIFT_MCAND;
            ST_SHIFT_MCAND:  st_d.step = mplier_nz ? ST_TAKE_BIT : ST_STORE;
            ST_STORE:        st_d.step = ST_FINISH;
            ST_FINISH:       st_d.step = ST_IDLE;
            default:         st_d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{step: ST_IDLE};
        else        st_q <= st_d;
    end

    // control word decode, one register transfer per step
    always_comb begin
        cw = '0;
        unique case (st_q.step)
            ST_CLR_BASE: begin
                cw.dst = REG_BASE; cw.src_a = REG_BASE; cw.src_b = REG_BASE;
                cw.fn = FN_SUB; cw.reg_we = 1'b1;
            end
            ST_LD_MCAND: begin
                cw.dst = REG_MCAND; cw.src_a = REG_BASE; cw.use_imm = 1'b1;
                cw.imm = OFS_MCAND; cw.fn = FN_ADD; cw.wb_mem = 1'b1; cw.reg_we = 1'b1;
            end
            ST_LD_MPLIER: begin
                cw.dst = REG_MPLIER; cw.src_a = REG_BASE; cw.use_imm = 1'b1;
                cw.imm = OFS_MPLIER; cw.fn = FN_ADD; cw.wb_mem = 1'b1; cw.reg_we = 1'b1;
            end
            ST_CLR_ACC: begin
                cw.dst = REG_ACC; cw.src_a = REG_ACC; cw.src_b = REG_ACC;
                cw.fn = FN_SUB; cw.reg_we = 1'b1;
            end
            ST_TAKE_BIT: begin
                cw.dst = REG_BIT; cw.src_a = REG_MPLIER; cw.use_imm = 1'b1;
                cw.imm = 3'd1; cw.fn = FN_AND; cw.reg_we = 1'b1;
            end
            ST_SHIFT_MPLIER: begin
                cw.dst = REG_MPLIER; cw.src_a = REG_MPLIER; cw.fn = FN_SRL; cw.reg_we = 1'b1;
            end
            ST_ACCUM: begin
                cw.dst = REG_ACC; cw.src_a = REG_ACC; cw.src_b = REG_MCAND;
                cw.fn = FN_ADD; cw.reg_we = 1'b1;
            end
            ST_SHIFT_MCAND: begin
                cw.dst = REG_MCAND; cw.src_a = REG_MCAND; cw.fn = FN_SLL; cw.reg_we = 1'b1;
            end
            ST_STORE: begin
                cw.src_a = REG_BASE; cw.src_b = REG_ACC; cw.use_imm = 1'b1;
                cw.imm = OFS_PROD; cw.fn = FN_ADD; cw.mem_we = 1'b1;
            end
            default: cw = '0;
        endcase
    end

    assign busy = (st_q.step != ST_IDLE);
    assign done = (st_q.step == ST_FINISH);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R7
    skip_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step == ST_SHIFT_MPLIER && !bit_set) |=> (st_q.step == ST_SHIFT_MCAND));

endmodule

// File: rtl/seqmul_regs.sv
module seqmul_regs #(
    parameter int DW      = 16,
    parameter int NREG    = 8,
    parameter int BIT_REG = 4,
    parameter int CNT_REG = 2,
    localparam int IW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [IW-1:0] ra_a,
    input  logic [IW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic          tap_bit,
    output logic          tap_nz
);

    logic [DW-1:0] rf_d [NREG];
    logic [DW-1:0] rf_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) rf_d[i] = rf_q[i];
        if (we) rf_d[wa] = wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= rf_d[i];
        end
    end

    assign rd_a    = rf_q[ra_a];
    assign rd_b    = rf_q[ra_b];
    assign tap_bit = rf_q[BIT_REG][0];
    assign tap_nz  = |rf_q[CNT_REG];

endmodule

// File: rtl/seqmul_alu.sv
module seqmul_alu
    import seqmul_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_fn_e       fn,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);

    always_comb begin
        unique case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_SRL:  y = {1'b0, a[DW-1:1]};
            FN_SLL:  y = {a[DW-2:0], 1'b0};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/seqmul_ram.sv
module seqmul_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd,
    input  logic [AW-1:0] addr2,
    output logic [DW-1:0] rd2
);

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[addr] = wd;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end

    assign rd  = mem_q[addr];
    assign rd2 = mem_q[addr2];

endmodule

// File: rtl/seqmul_core.sv
module seqmul_core
    import seqmul_pkg::*;
#(
    parameter int OP_W      = 8,
    parameter int MEM_DEPTH = 8,
    localparam int DW       = 2 * OP_W,
    localparam int AW       = $clog2(MEM_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          busy,
    output logic          done
);

    cword_t        cw;
    logic          bit_set, mplier_nz;
    logic [DW-1:0] rd_a, rd_b, opnd_b, alu_y, mem_rd, wb_data;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wd;

    seqmul_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bit_set   (bit_set),
        .mplier_nz (mplier_nz),
        .cw        (cw),
        .busy      (busy),
        .done      (done)
    );

    seqmul_regs #(
        .DW      (DW),
        .NREG    (1 << RIDX_W),
        .BIT_REG (int'(REG_BIT)),
        .CNT_REG (int'(REG_MPLIER))
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cw.reg_we),
        .wa      (cw.dst),
        .wd      (wb_data),
        .ra_a    (cw.src_a),
        .ra_b    (cw.src_b),
        .rd_a    (rd_a),
        .rd_b    (rd_b),
        .tap_bit (bit_set),
        .tap_nz  (mplier_nz)
    );

    assign opnd_b = cw.use_imm ? {{(DW-IMM_W){1'b0}}, cw.imm} : rd_b;

    seqmul_alu #(.DW(DW)) i_alu (
        .fn (cw.fn),
        .a  (rd_a),
        .b  (opnd_b),
        .y  (alu_y)
    );

    // datapath owns the memory while busy, host otherwise
    assign ram_we   = busy ? cw.mem_we : host_we;
    assign ram_addr = busy ? alu_y[AW-1:0] : host_addr;
    assign ram_wd   = busy ? rd_b : host_wdata;

    seqmul_ram #(.DW(DW), .DEPTH(MEM_DEPTH)) i_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wd    (ram_wd),
        .rd    (mem_rd),
        .addr2 (host_addr),
        .rd2   (host_rdata)
    );

    assign wb_data = cw.wb_mem ? mem_rd : alu_y;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    // R3
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R5
    store_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ram_we) |-> (ram_addr == AW'(OFS_PROD)));

    // R6
    done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

// File: tb/test_seqmul_core.sv
module test_seqmul_core;

    localparam int OP_W  = 8;
    localparam int DEPTH = 8;
    localparam int DW    = 2 * OP_W;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          busy, done;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    seqmul_core #(.OP_W(OP_W), .MEM_DEPTH(DEPTH)) i_seqmul_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .done       (done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic mem_write(input int a, input logic [DW-1:0] v);
        @(negedge clk);
        host_addr = AW'(a); host_wdata = v; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic mem_read(input int a, output logic [DW-1:0] v);
        @(negedge clk);
        host_addr = AW'(a);
        #1 v = host_rdata;
    endtask

    function automatic int pass_cycles(input int b);
        int tot = 0;
        int v = b;
        do begin
            tot += 3 + (v & 1);
            v = v >> 1;
        end while (v != 0);
        return tot;
    endfunction

    task automatic t_reset();
        #1;
        // R1
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
    endtask

    task automatic t_idle_hold();
        logic [DW-1:0] v;
        mem_write(2, 16'h5A5A);
        repeat (10) begin
            @(negedge clk);
            // R2
            check(busy == 1'b0, "R2 idle busy", busy, 0);
        end
        mem_read(2, v);
        check(v == 16'h5A5A, "R2 word unchanged", v, 16'h5A5A);
    endtask

    task automatic t_mul(input int a, input int b);
        logic [DW-1:0] v;
        int n = 0;
        int exp_n;
        mem_write(0, DW'(a));
        mem_write(1, DW'(b));
        mem_write(2, 16'hBEEF);
        exp_n = 6 + pass_cycles(b);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1;
        // R3
        check(busy == 1'b1, "R3 busy after start", busy, 1);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        // R7
        check(n == exp_n, "R7 done latency", n, exp_n);
        @(negedge clk);
        // R6
        check(done == 1'b0, "R6 done one cycle", done, 0);
        check(busy == 1'b0, "R6 idle after done", busy, 0);
        mem_read(2, v);
        // R4 R8
        check(v == DW'(a * b), "R4 product", v, a * b);
        mem_read(0, v);
        // R5
        check(v == DW'(a), "R5 multiplicand kept", v, a);
        mem_read(1, v);
        check(v == DW'(b), "R5 multiplier kept", v, b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_hold();
        t_mul(5, 3);
        t_mul(0, 77);
        t_mul(77, 0);
        t_mul(255, 255);
        t_mul(255, 0);
        t_mul(1, 128);
        t_mul(200, 170);
        t_mul(13, 1);
        for (int k = 0; k < 6; k++) t_mul($urandom_range(0, 255), $urandom_range(0, 255));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule